// File: doc/BRIEF.md
# Register ALU Execution Unit With Condition Flags

This block executes the register-only arithmetic and logic operations of a small 16-bit processor. It has eight general registers. It accepts one 10-bit instruction word when `issue_i` is high. It reads the source and destination registers, forms a result in a single shared adder or logic unit, and writes the result back to the destination register. It then updates the sign, zero, carry and overflow flags according to the rule of that operation.

Each executed instruction is acknowledged one clock later by a `done_o` pulse. The pulse carries the cycle cost that the wider processor would charge for it. A move into the highest register also raises `jump_o`, because that register serves as the program counter. Instruction words outside the decoded groups are dropped without any effect. A combinational read port lets the surrounding logic observe any register.

Top module: `alu16_exec`

## Requirements
- R1: While reset is asserted, and after it is released, all eight registers read 0, every flag is 0, and `done_o` and `jump_o` are 0.
- R2: Opcode 0011 in bits 9:6, with source in bits 5:3 and destination in bits 2:0, adds: dst <= dst + src. C is the carry out. OV is set when both operands share a sign and the result's sign differs. S is result bit 15, and Z is set when the result is zero.
- R3: Opcode 0100 subtracts: dst <= dst - src. C is 1 when no borrow occurs (dst >= src, unsigned). OV is signed overflow of dst - src. S and Z are set as in R2.
- R4: Opcode 0101 (compare) sets S, Z, C and OV exactly as R3 would, and leaves the destination register unchanged.
- R5: Opcodes 0110 (AND) and 0111 (XOR) write the bitwise result and update only S and Z, keeping C and OV. XOR with equal source and destination fields clears the register and sets Z.
- R6: Opcode 0000 with function 001, 010 or 011 in bits 5:3 increments, decrements or one's-complements the register in bits 2:0. Only S and Z are updated.
- R7: Function 100 negates: reg <= 0 - reg. C is 1 exactly when the old value was 0. OV is 1 exactly when the old value was 0x8000.
- R8: Function 101 adds the carry flag: reg <= reg + C. C and OV are taken from that addition, together with S and Z.
- R9: Opcode 0010 moves src to dst and sets S and Z from the moved value; equal fields act as a test. A destination of register 7 raises `jump_o` together with `done_o`.
- R10: `done_o` pulses in the cycle after each executed issue. `cycles_o` is then 7 when the destination field is 6 or 7, and 6 otherwise.
- R11: Opcode 0001, opcodes 1xxx, and functions 000, 110 and 111 of opcode 0000 write nothing, change no flag and give no `done_o`.
- R12: With `issue_i` low, registers, flags and `done_o` stay unchanged whatever `insn_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction word valid this cycle |
| insn_i | input | 10 | Instruction word |
| rd_sel_i | input | 3 | Register select for the observation port |
| rd_data_o | output | 16 | Contents of the selected register (combinational) |
| flag_s_o | output | 1 | Sign flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_ov_o | output | 1 | Overflow flag |
| done_o | output | 1 | One-cycle acknowledge of an executed instruction |
| cycles_o | output | 4 | Cycle cost of the acknowledged instruction |
| jump_o | output | 1 | Acknowledged instruction was a move into register 7 |

## Verification
Every result is due one clock edge after the edge that samples `issue_i`. At that edge the register write, the flags, `done_o`, `cycles_o` and `jump_o` all land together. The bench drives each word on a falling edge and drops `issue_i` on the next falling edge. It samples the acknowledge outputs at that falling edge, which is half a cycle after they settle. It reads registers through the combinational port only after that, so every value it checks is the settled outcome of exactly one instruction.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_ADD, K_SUB, K_AND, K_XOR, K_MOV,
    K_INC, K_DEC, K_COM, K_NEG, K_ADC
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  legal;   // word belongs to a decoded group
    logic  wr_en;   // result goes back to the destination
    logic  upd_cv;  // carry and overflow follow the adder
    logic  jump;    // move into the program-counter register
  } ctrl_t;

  localparam logic [3:0] OPC_SINGLE = 4'b0000;
  localparam logic [3:0] OPC_MOVE   = 4'b0010;
  localparam logic [3:0] OPC_ADD    = 4'b0011;
  localparam logic [3:0] OPC_SUB    = 4'b0100;
  localparam logic [3:0] OPC_CMP    = 4'b0101;
  localparam logic [3:0] OPC_AND    = 4'b0110;
  localparam logic [3:0] OPC_XOR    = 4'b0111;

endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
  import alu16_pkg::*;
#(
  parameter int REG_AW = 3,
  localparam int IW = 4 + 2 * REG_AW
) (
  input  logic [IW-1:0] insn,
  output ctrl_t         ctrl
);

  localparam logic [REG_AW-1:0] PC_REG = {REG_AW{1'b1}};

  logic [3:0]        opc;
  logic [REG_AW-1:0] fld_a;
  logic [REG_AW-1:0] fld_b;

  assign opc   = insn[IW-1 -: 4];
  assign fld_a = insn[2*REG_AW-1 -: REG_AW];
  assign fld_b = insn[REG_AW-1:0];

  always_comb begin
    ctrl        = '0;
    ctrl.kind   = K_NONE;
    ctrl.legal  = 1'b1;
    ctrl.wr_en  = 1'b1;
    unique case (opc)
      OPC_ADD:  begin ctrl.kind = K_ADD; ctrl.upd_cv = 1'b1; end
      OPC_SUB:  begin ctrl.kind = K_SUB; ctrl.upd_cv = 1'b1; end
      OPC_CMP:  begin ctrl.kind = K_SUB; ctrl.upd_cv = 1'b1; ctrl.wr_en = 1'b0; end
      OPC_AND:  ctrl.kind = K_AND;
      OPC_XOR:  ctrl.kind = K_XOR;
      OPC_MOVE: begin ctrl.kind = K_MOV; ctrl.jump = (fld_b == PC_REG); end
      OPC_SINGLE: begin
        if (fld_a == REG_AW'(1))      ctrl.kind = K_INC;
        else if (fld_a == REG_AW'(2)) ctrl.kind = K_DEC;
        else if (fld_a == REG_AW'(3)) ctrl.kind = K_COM;
        else if (fld_a == REG_AW'(4)) begin ctrl.kind = K_NEG; ctrl.upd_cv = 1'b1; end
        else if (fld_a == REG_AW'(5)) begin ctrl.kind = K_ADC; ctrl.upd_cv = 1'b1; end
        else begin ctrl.legal = 1'b0; ctrl.wr_en = 1'b0; end
      end
      default: begin ctrl.legal = 1'b0; ctrl.wr_en = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  kind_e             kind,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] dst_val,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              c_out,
  output logic              ov_out
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] op_a;
  logic [DATA_W-1:0] op_b;
  logic              cin;
  logic [DATA_W:0]   sum;

  // operand steering for the single shared adder
  always_comb begin
    op_a = dst_val;
    op_b = '0;
    cin  = 1'b0;
    unique case (kind)
      K_ADD: op_b = src_val;
      K_SUB: begin op_b = ~src_val; cin = 1'b1; end
      K_INC: cin = 1'b1;
      K_DEC: op_b = '1;
      K_NEG: begin op_a = '0; op_b = ~dst_val; cin = 1'b1; end
      K_ADC: cin = c_in;
      default: ;
    endcase
  end

  assign sum    = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, cin};
  assign c_out  = sum[DATA_W];
  assign ov_out = (op_a[MSB] == op_b[MSB]) && (sum[MSB] != op_a[MSB]);

  always_comb begin
    unique case (kind)
      K_AND:   res = dst_val & src_val;
      K_XOR:   res = dst_val ^ src_val;
      K_COM:   res = ~dst_val;
      K_MOV:   res = src_val;
      default: res = sum[DATA_W-1:0];
    endcase
  end

endmodule

// File: rtl/alu16_regfile.sv
module alu16_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra_src,
  output logic [DATA_W-1:0] rd_src,
  input  logic [AW-1:0]     ra_dst,
  output logic [DATA_W-1:0] rd_dst,
  input  logic [AW-1:0]     ra_obs,
  output logic [DATA_W-1:0] rd_obs
);

  logic [DATA_W-1:0] mem_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem_q[g] <= '0;
      else if (we && (waddr == AW'(g)))            mem_q[g] <= wdata;
    end
  end

  assign rd_src = mem_q[ra_src];
  assign rd_dst = mem_q[ra_dst];
  assign rd_obs = mem_q[ra_obs];

endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
  import alu16_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NREG     = 8,
  parameter int BASE_CYC = 6,
  parameter int CYC_W    = 4,
  localparam int AW      = $clog2(NREG),
  localparam int IW      = 4 + 2 * AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [IW-1:0]     insn_i,
  input  logic [AW-1:0]     rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              flag_s_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_ov_o,
  output logic              done_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic              jump_o
);

  localparam logic [AW-1:0] HI_FIRST = AW'(NREG - 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  ctrl_t             ctrl;
  logic [AW-1:0]     src_a;
  logic [AW-1:0]     dst_a;
  logic [DATA_W-1:0] src_v, dst_v, res;
  logic              c_new, ov_new;
  logic              fire;

  assign src_a = insn_i[2*AW-1 -: AW];
  assign dst_a = insn_i[AW-1:0];
  assign fire  = issue_i && ctrl.legal;

  alu16_decode #(.REG_AW(AW)) u_dec (.insn(insn_i), .ctrl(ctrl));

  alu16_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_q),
    .we(fire && ctrl.wr_en), .waddr(dst_a), .wdata(res),
    .ra_src(src_a), .rd_src(src_v),
    .ra_dst(dst_a), .rd_dst(dst_v),
    .ra_obs(rd_sel_i), .rd_obs(rd_data_o)
  );

  alu16_datapath #(.DATA_W(DATA_W)) u_dp (
    .kind(ctrl.kind), .src_val(src_v), .dst_val(dst_v), .c_in(flag_c_o),
    .res(res), .c_out(c_new), .ov_out(ov_new)
  );

  // next-state
  logic             s_d, z_d, c_d, ov_d, done_d, jump_d;
  logic [CYC_W-1:0] cyc_d;

  always_comb begin
    s_d    = flag_s_o;
    z_d    = flag_z_o;
    c_d    = flag_c_o;
    ov_d   = flag_ov_o;
    done_d = fire;
    jump_d = fire && ctrl.jump;
    cyc_d  = cycles_o;
    if (fire) begin
      s_d   = res[DATA_W-1];
      z_d   = (res == '0);
      cyc_d = CYC_W'(BASE_CYC) + CYC_W'(dst_a >= HI_FIRST);
      if (ctrl.upd_cv) begin
        c_d  = c_new;
        ov_d = ov_new;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      flag_s_o  <= 1'b0;
      flag_z_o  <= 1'b0;
      flag_c_o  <= 1'b0;
      flag_ov_o <= 1'b0;
      done_o    <= 1'b0;
      jump_o    <= 1'b0;
      cycles_o  <= '0;
    end else begin
      flag_s_o  <= s_d;
      flag_z_o  <= z_d;
      flag_c_o  <= c_d;
      flag_ov_o <= ov_d;
      done_o    <= done_d;
      jump_o    <= jump_d;
      cycles_o  <= cyc_d;
    end
  end

endmodule

// File: rtl/alu16_exec_chk.sv
module alu16_exec_chk #(
  parameter int NREG  = 8,
  parameter int CYC_W = 4,
  localparam int AW   = $clog2(NREG),
  localparam int IW   = 4 + 2 * AW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_i,
  input logic [IW-1:0]    insn_i,
  input logic             flag_s_o,
  input logic             flag_z_o,
  input logic             flag_c_o,
  input logic             flag_ov_o,
  input logic             done_o,
  input logic [CYC_W-1:0] cycles_o,
  input logic             jump_o
);

  logic [3:0]    opc;
  logic [AW-1:0] fn;
  logic          undecoded;

  assign opc = insn_i[IW-1 -: 4];
  assign fn  = insn_i[2*AW-1 -: AW];
  assign undecoded = opc[3] || (opc == 4'b0001) ||
                     ((opc == 4'b0000) && (fn == AW'(0) || fn == AW'(6) || fn == AW'(7)));

  p_done_after_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(issue_i));

  p_cycle_cost_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cycles_o == (($past(insn_i[AW-1:0]) >= AW'(NREG - 2)) ? CYC_W'(7) : CYC_W'(6))));

  p_jump_on_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |-> (done_o && $past(opc) == 4'b0010));

  p_undecoded_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && undecoded) |=> (!done_o && $stable(flag_s_o) && $stable(flag_z_o)
                                && $stable(flag_c_o) && $stable(flag_ov_o)));

  p_logic_keeps_cv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (opc == 4'b0110 || opc == 4'b0111)) |=> ($stable(flag_c_o) && $stable(flag_ov_o)));

  p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!done_o && $stable(flag_s_o) && $stable(flag_z_o)
                  && $stable(flag_c_o) && $stable(flag_ov_o)));

endmodule

bind alu16_exec alu16_exec_chk #(.NREG(NREG), .CYC_W(CYC_W)) u_chk (.*);

// File: tb/tb_alu16_exec.sv
`timescale 1ns/1ps
module tb_alu16_exec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [9:0]  insn_i = '0;
  logic [2:0]  rd_sel_i = '0;
  logic [15:0] rd_data_o;
  logic        flag_s_o, flag_z_o, flag_c_o, flag_ov_o, done_o, jump_o;
  logic [3:0]  cycles_o;

  int checks = 0;
  int errors = 0;
  logic       ob_done, ob_jump;
  logic [3:0] ob_cyc;

  always #2 clk = ~clk;

  alu16_exec dut (.*);

  localparam logic [3:0] MOV = 4'b0010, ADD = 4'b0011, SUB = 4'b0100,
                         CMP = 4'b0101, AND_ = 4'b0110, XOR_ = 4'b0111;

  function automatic logic [9:0] w2(logic [3:0] op, int s, int d);
    return {op, 3'(s), 3'(d)};
  endfunction
  function automatic logic [9:0] w1(int f, int r);
    return {4'b0000, 3'(f), 3'(r)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exec(logic [9:0] w);
    @(negedge clk);
    issue_i = 1'b1; insn_i = w;
    @(negedge clk);
    issue_i = 1'b0;
    ob_done = done_o; ob_cyc = cycles_o; ob_jump = jump_o;
  endtask

  task automatic rreg(int r, output logic [15:0] v);
    rd_sel_i = 3'(r);
    #0.5;
    v = rd_data_o;
  endtask

  task automatic set_reg(int r, logic [15:0] val);
    exec(w2(XOR_, r, r));
    for (int i = 15; i >= 0; i--) begin
      exec(w2(ADD, r, r));
      if (val[i]) exec(w1(1, r));
    end
  endtask

  task automatic chk_reg(string tag, int r, logic [15:0] exp);
    logic [15:0] v;
    rreg(r, v);
    chk(tag, 32'(v), 32'(exp));
  endtask

  task automatic chk_flags(string tag, logic s, logic z, logic c, logic ov);
    chk(tag, {28'd0, flag_s_o, flag_z_o, flag_c_o, flag_ov_o}, {28'd0, s, z, c, ov});
  endtask

  task automatic t_reset();
    for (int r = 0; r < 8; r++) chk_reg("R1 reg zero", r, 16'h0);
    chk_flags("R1 flags", 0, 0, 0, 0);
    chk("R1 done/jump", {30'd0, done_o, jump_o}, 32'd0);
  endtask

  task automatic t_add();
    set_reg(1, 16'h7FFF); set_reg(2, 16'h0001);
    exec(w2(ADD, 2, 1));
    chk_reg("R2 add ovf result", 1, 16'h8000);
    chk_flags("R2 add ovf flags", 1, 0, 0, 1);
    chk("R10 cycles low dest", 32'(ob_cyc), 32'd6);
    chk("R10 done", 32'(ob_done), 32'd1);
    set_reg(3, 16'hFFFF);
    exec(w2(ADD, 2, 3));
    chk_reg("R2 add wrap result", 3, 16'h0000);
    chk_flags("R2 add wrap flags", 0, 1, 1, 0);
  endtask

  task automatic t_sub();
    set_reg(3, 16'd5); set_reg(4, 16'd3);
    exec(w2(SUB, 3, 4));
    chk_reg("R3 sub borrow result", 4, 16'hFFFE);
    chk_flags("R3 sub borrow flags", 1, 0, 0, 0);
    set_reg(4, 16'h8000); set_reg(5, 16'h0001);
    exec(w2(SUB, 5, 4));
    chk_reg("R3 sub ovf result", 4, 16'h7FFF);
    chk_flags("R3 sub ovf flags", 0, 0, 1, 1);
  endtask

  task automatic t_cmp();
    set_reg(1, 16'd10); set_reg(2, 16'd10);
    exec(w2(CMP, 1, 2));
    chk_reg("R4 cmp no write", 2, 16'd10);
    chk_flags("R4 cmp equal flags", 0, 1, 1, 0);
    set_reg(2, 16'd4);
    exec(w2(CMP, 1, 2));
    chk_reg("R4 cmp no write lt", 2, 16'd4);
    chk_flags("R4 cmp less flags", 1, 0, 0, 0);
  endtask

  task automatic t_logic();
    set_reg(1, 16'h00F0); set_reg(2, 16'h0F00); set_reg(3, 16'h8000);
    set_reg(5, 16'h1234); set_reg(6, 16'hFFFF); set_reg(0, 16'h0001);
    exec(w2(ADD, 0, 6));                    // C=1, OV=0, Z=1
    exec(w2(AND_, 1, 2));
    chk_reg("R5 and result", 2, 16'h0000);
    chk_flags("R5 and keeps C", 0, 1, 1, 0);
    exec(w2(XOR_, 1, 3));
    chk_reg("R5 xor result", 3, 16'h80F0);
    chk_flags("R5 xor flags", 1, 0, 1, 0);
    exec(w2(XOR_, 5, 5));
    chk_reg("R5 clear", 5, 16'h0000);
    chk_flags("R5 clear flags", 0, 1, 1, 0);
  endtask

  task automatic t_single();
    set_reg(1, 16'hFFFF); set_reg(2, 16'h0000); set_reg(3, 16'h00FF);
    set_reg(4, 16'h8000); set_reg(5, 16'h0001);
    exec(w2(SUB, 5, 4));                    // C=1, OV=1
    exec(w1(1, 1));
    chk_reg("R6 inc wrap", 1, 16'h0000);
    chk_flags("R6 inc keeps C OV", 0, 1, 1, 1);
    exec(w1(2, 2));
    chk_reg("R6 dec wrap", 2, 16'hFFFF);
    chk_flags("R6 dec flags", 1, 0, 1, 1);
    exec(w1(3, 3));
    chk_reg("R6 complement", 3, 16'hFF00);
    chk_flags("R6 com flags", 1, 0, 1, 1);
  endtask

  task automatic t_neg();
    set_reg(1, 16'h0000); set_reg(2, 16'h8000); set_reg(6, 16'd5);
    exec(w1(4, 1));
    chk_reg("R7 neg zero", 1, 16'h0000);
    chk_flags("R7 neg zero flags", 0, 1, 1, 0);
    exec(w1(4, 2));
    chk_reg("R7 neg min", 2, 16'h8000);
    chk_flags("R7 neg min flags", 1, 0, 0, 1);
    exec(w1(4, 6));
    chk_reg("R7 neg five", 6, 16'hFFFB);
    chk_flags("R7 neg five flags", 1, 0, 0, 0);
    chk("R10 cycles reg6", 32'(ob_cyc), 32'd7);
  endtask

  task automatic t_adc();
    set_reg(1, 16'h0000); set_reg(2, 16'h7FFF); set_reg(3, 16'h1234);
    exec(w1(4, 1));                         // C=1
    exec(w1(5, 2));
    chk_reg("R8 adc carry in", 2, 16'h8000);
    chk_flags("R8 adc ovf flags", 1, 0, 0, 1);
    exec(w1(5, 3));
    chk_reg("R8 adc no carry", 3, 16'h1234);
    chk_flags("R8 adc flags", 0, 0, 0, 0);
  endtask

  task automatic t_move();
    set_reg(3, 16'hABCD); set_reg(0, 16'h0000);
    exec(w2(MOV, 3, 6));
    chk_reg("R9 move", 6, 16'hABCD);
    chk_flags("R9 move flags", 1, 0, 0, 0);
    chk("R9 no jump r6", 32'(ob_jump), 32'd0);
    chk("R10 move cycles r6", 32'(ob_cyc), 32'd7);
    exec(w2(MOV, 3, 7));
    chk_reg("R9 move pc", 7, 16'hABCD);
    chk("R9 jump r7", 32'(ob_jump), 32'd1);
    exec(w2(MOV, 0, 0));
    chk_flags("R9 test zero", 0, 1, 0, 0);
    chk("R10 test cycles r0", 32'(ob_cyc), 32'd6);
    chk_reg("R9 test keeps", 0, 16'h0000);
  endtask

  task automatic t_undecoded();
    logic [3:0] f0;
    set_reg(2, 16'h8001);
    exec(w1(4, 0));                         // r0=0: C=1, Z=1
    f0 = {flag_s_o, flag_z_o, flag_c_o, flag_ov_o};
    foreach (insn_i[i]) begin end
    exec({4'b0001, 3'd0, 3'd2});
    chk("R11 shift group no done", 32'(ob_done), 32'd0);
    exec(w1(6, 2));
    chk("R11 func6 no done", 32'(ob_done), 32'd0);
    exec(w1(0, 2));
    exec(w1(7, 2));
    exec({4'b1000, 3'd1, 3'd2});
    chk("R11 opcode 1xxx no done", 32'(ob_done), 32'd0);
    chk_reg("R11 reg unchanged", 2, 16'h8001);
    chk("R11 flags unchanged", {28'd0, flag_s_o, flag_z_o, flag_c_o, flag_ov_o}, {28'd0, f0});
  endtask

  task automatic t_idle();
    logic [3:0] f0;
    set_reg(4, 16'h0F0F);
    f0 = {flag_s_o, flag_z_o, flag_c_o, flag_ov_o};
    @(negedge clk);
    insn_i = w1(3, 4);
    repeat (3) @(negedge clk);
    chk("R12 idle no done", 32'(done_o), 32'd0);
    chk_reg("R12 idle reg", 4, 16'h0F0F);
    chk("R12 idle flags", {28'd0, flag_s_o, flag_z_o, flag_c_o, flag_ov_o}, {28'd0, f0});
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_single();
    t_neg();
    t_adc();
    t_move();
    t_undecoded();
    t_idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule